// File: doc/BRIEF.md
# Dual-Channel Sample Sequencer with Serial Streaming

This block sits between one shared 8-bit converter and a serial transmit line. The converter's input comes through a two-way analog switch, and the block drives that switch itself. Each end-of-conversion strobe advances a small sequencer. After every change of input, a fixed number of results are thrown away while the analog path settles. The next results are kept, and once a set number have been kept the switch flips to the other input. No processor takes part in any of this.

Each kept result is stored in a circular buffer along with a one-bit channel tag. The buffer drains at a baud rate set by the caller's tick. Each sample goes out as a plain 8N1 frame. A header frame is inserted whenever the channel differs from the sample sent before it, so the receiver can tell the two streams apart.

Capture is meant to run in bursts. During a capture window the buffer fills faster than it drains. When capture is switched off, writing stops at once and the buffer keeps emptying onto the line.

Top module: `dual_sample_streamer`

## Requirements
- R1: `muxSel` is 0 after reset. It inverts on the strobe that delivers the KEEP_COUNT-th kept result on the current input, and it changes on no other cycle.
- R2: After reset, and after every inversion of `muxSel`, the first SETTLE_COUNT (default 3) accepted results are discarded. They never enter the buffer and never reach the line.
- R3: A kept result that arrives while the buffer holds DEPTH entries is dropped and sets `overflow`. `overflow` stays 1 until a cycle with `ovfClear` high and no new drop; it is 0 after reset.
- R4: Kept samples are transmitted in the order they were captured, each carrying the 8-bit result unchanged.
- R5: Every frame is 10 bit times: a start bit of 0, eight data bits least significant bit first, then a stop bit of 1. `txLine` is 1 whenever no frame is in progress.
- R6: A header frame with the byte 0xA0 OR channel (0xA0 for input 0, 0xA1 for input 1) is sent before a sample whose channel differs from the last sample sent, and before the first sample after reset.
- R7: While `captureEn` is 0, strobes are ignored: nothing is written, `muxSel` holds, and the discard and keep counts do not move. Samples already in the buffer keep transmitting.
- R8: A frame starts only on a `baudTick` cycle when the buffer is not empty. `txLine` changes only on `baudTick` cycles, so each bit lasts one tick interval.
- R9: After reset, `txLine` is 1, `bufEmpty` is 1, `bufFull` is 0, `overflow` is 0 and `muxSel` is 0.
- R10: `bufEmpty` is 1 exactly when the buffer holds no entries. `bufFull` is 1 exactly when it holds DEPTH entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| convStrobe | input | 1 | One-cycle end-of-conversion pulse |
| convData | input | DATA_W | Conversion result valid with the strobe |
| captureEn | input | 1 | Capture window; strobes are ignored while low |
| baudTick | input | 1 | One-cycle pulse per serial bit time |
| ovfClear | input | 1 | Clears the sticky overflow flag |
| muxSel | output | 1 | Analog input select |
| txLine | output | 1 | Serial output, idles high |
| bufEmpty | output | 1 | Buffer holds no entries |
| bufFull | output | 1 | Buffer holds DEPTH entries |
| overflow | output | 1 | Sticky flag: a kept result was dropped |

## Verification
Several checks are made on every cycle:
- `muxSel` moves only on an accepted strobe.
- A switch is never followed directly by a write.
- Nothing is written while capture is off.
- A drop into a full buffer raises the flag.
- The line is high while idle and low on the cycle after a frame load.
- Serial activity happens only on tick cycles.

Other behaviours need the bench's scenarios. These are the exact discard and keep pattern across two full rotations of the inputs, the placement and value of header frames, the order and bit content of the decoded bytes, the sticky flag surviving a full drain, and strobes ignored during a gap leaving the sequencer position untouched.

// File: rtl/dss_pkg.sv
package dss_pkg;

  // Per-cycle commands from the control module to the datapath
  typedef struct packed {
    logic wrEn;      // kept result to be written
    logic wrChan;    // channel tag of that result
    logic loadHdr;   // start a header frame
    logic loadData;  // start a data frame and pop the head entry
    logic shift;     // advance the frame in progress by one bit
  } dss_strobe_t;

  // Header byte is {HDR_PREFIX, channel}: 0xA0 or 0xA1
  localparam logic [6:0] HDR_PREFIX = 7'h50;

endpackage

// File: rtl/dss_ctrl.sv
module dss_ctrl
  import dss_pkg::*;
#(
  parameter int SETTLE_COUNT = 3,
  parameter int KEEP_COUNT   = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        convStrobe,
  input  logic        captureEn,
  input  logic        baudTick,
  input  logic        bufEmpty,
  input  logic        headChan,
  input  logic        frameFree,
  input  logic        busy,
  output logic        muxSel,
  output dss_strobe_t str
);

  localparam int KW = $clog2(KEEP_COUNT + 1);

  logic          accept;
  logic          settled;
  logic          switchNow;
  logic [KW-1:0] keepCnt;
  logic          lastChan;
  logic          lastValid;
  logic          needHdr;

  assign accept    = convStrobe && captureEn;
  assign switchNow = accept && settled && (keepCnt == KW'(KEEP_COUNT - 1));

  // Settling discard counter, present only when discards are configured
  if (SETTLE_COUNT > 0) begin : g_settle
    localparam int SW = $clog2(SETTLE_COUNT + 1);
    logic [SW-1:0] settleCnt;

    always_ff @(posedge clk) begin
      if (!rstN)                   settleCnt <= '0;
      else if (switchNow)          settleCnt <= '0;
      else if (accept && !settled) settleCnt <= settleCnt + 1'b1;
    end
    assign settled = (settleCnt == SW'(SETTLE_COUNT));

    // R2: the strobe after a switch is never written
    p_settle_gap_r2: assert property (@(posedge clk) disable iff (!rstN)
      switchNow |=> !str.wrEn);
  end else begin : g_nosettle
    assign settled = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keepCnt <= '0;
      muxSel  <= 1'b0;
    end else if (switchNow) begin
      keepCnt <= '0;
      muxSel  <= ~muxSel;
    end else if (accept && settled) begin
      keepCnt <= keepCnt + 1'b1;
    end
  end

  // Transmit scheduling: header whenever the channel differs from the last one sent
  assign needHdr = !lastValid || (headChan != lastChan);

  always_comb begin
    str        = '0;
    str.wrEn   = accept && settled;
    str.wrChan = muxSel;
    if (baudTick) begin
      if (frameFree && !bufEmpty) begin
        if (needHdr) str.loadHdr  = 1'b1;
        else         str.loadData = 1'b1;
      end else if (busy) begin
        str.shift = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastChan  <= 1'b0;
      lastValid <= 1'b0;
    end else if (str.loadHdr) begin
      lastChan  <= headChan;
      lastValid <= 1'b1;
    end
  end

  // R1: select moves only on an accepted strobe
  p_sel_holds_r1: assert property (@(posedge clk) disable iff (!rstN)
    !accept |=> $stable(muxSel));
  // R7: no write while capture is off
  p_off_no_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    !captureEn |-> !str.wrEn);
  // R8: serial activity only on tick cycles
  p_tick_gates_tx_r8: assert property (@(posedge clk) disable iff (!rstN)
    (str.loadHdr || str.loadData || str.shift) |-> baudTick);
  // R6: at most one frame kind started per cycle
  p_one_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({str.loadHdr, str.loadData}));

endmodule

// File: rtl/dss_burst_fifo.sv
module dss_burst_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrReq,
  input  logic              wrChan,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdPop,
  input  logic              ovfClear,
  output logic              headChan,
  output logic [DATA_W-1:0] headData,
  output logic              empty,
  output logic              full,
  output logic              overflow
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W:0] mem [DEPTH];
  logic [AW-1:0]   wrPtr, rdPtr;
  logic [CW-1:0]   count;
  logic            doWrite, doPop;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign doWrite = wrReq && !full;
  assign doPop   = rdPop && !empty;

  always_ff @(posedge clk) begin
    if (doWrite) mem[wrPtr] <= {wrChan, wrData};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doWrite) wrPtr <= nextPtr(wrPtr);
      if (doPop)   rdPtr <= nextPtr(rdPtr);
      case ({doWrite, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // A drop has priority over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN)              overflow <= 1'b0;
    else if (wrReq && full) overflow <= 1'b1;
    else if (ovfClear)      overflow <= 1'b0;
  end

  assign headChan = mem[rdPtr][DATA_W];
  assign headData = mem[rdPtr][DATA_W-1:0];

  // R3: a drop raises the sticky flag
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && full) |=> overflow);
  // R3: the flag only falls through a clear
  p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !ovfClear) |=> overflow);
  // R4: control never pops an empty buffer
  p_pop_nonempty_r4: assert property (@(posedge clk) disable iff (!rstN)
    rdPop |-> !empty);

endmodule

// File: rtl/dss_serializer.sv
module dss_serializer #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic [DATA_W-1:0] loadByte,
  input  logic              shift,
  output logic              txLine,
  output logic              busy,
  output logic              frameFree
);

  localparam int FB   = DATA_W + 2;
  localparam int CNTW = $clog2(FB);

  logic [FB-1:0]   shReg;
  logic [CNTW-1:0] bitIdx;
  logic            lastBit;

  assign lastBit   = busy && (bitIdx == CNTW'(FB - 1));
  assign frameFree = !busy || lastBit;
  assign txLine    = shReg[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg  <= '1;
      busy   <= 1'b0;
      bitIdx <= '0;
    end else if (load) begin
      shReg  <= {1'b1, loadByte, 1'b0};
      busy   <= 1'b1;
      bitIdx <= '0;
    end else if (shift && busy) begin
      if (lastBit) begin
        shReg  <= '1;
        busy   <= 1'b0;
        bitIdx <= '0;
      end else begin
        shReg  <= {1'b1, shReg[FB-1:1]};
        bitIdx <= bitIdx + 1'b1;
      end
    end
  end

  // R5: the line is high whenever no frame is in progress
  p_idle_high_r5: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txLine);
  // R5: a frame opens with a low start bit
  p_start_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    load |=> !txLine);
  // R8: no load in the middle of a frame
  p_no_midframe_r8: assert property (@(posedge clk) disable iff (!rstN)
    load |-> frameFree);

endmodule

// File: rtl/dss_datapath.sv
module dss_datapath
  import dss_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dss_strobe_t       str,
  input  logic [DATA_W-1:0] convData,
  input  logic              ovfClear,
  output logic              headChan,
  output logic              bufEmpty,
  output logic              bufFull,
  output logic              overflow,
  output logic              txLine,
  output logic              busy,
  output logic              frameFree
);

  logic [DATA_W-1:0] headData;
  logic [DATA_W-1:0] frameByte;

  dss_burst_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_fifo (
    .clk      (clk),
    .rstN     (rstN),
    .wrReq    (str.wrEn),
    .wrChan   (str.wrChan),
    .wrData   (convData),
    .rdPop    (str.loadData),
    .ovfClear (ovfClear),
    .headChan (headChan),
    .headData (headData),
    .empty    (bufEmpty),
    .full     (bufFull),
    .overflow (overflow)
  );

  assign frameByte = str.loadHdr ? DATA_W'({HDR_PREFIX, headChan}) : headData;

  dss_serializer #(.DATA_W(DATA_W)) i_ser (
    .clk       (clk),
    .rstN      (rstN),
    .load      (str.loadHdr || str.loadData),
    .loadByte  (frameByte),
    .shift     (str.shift),
    .txLine    (txLine),
    .busy      (busy),
    .frameFree (frameFree)
  );

endmodule

// File: rtl/dual_sample_streamer.sv
module dual_sample_streamer
  import dss_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int SETTLE_COUNT = 3,
  parameter int KEEP_COUNT   = 16,
  parameter int DEPTH        = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              convStrobe,
  input  logic [DATA_W-1:0] convData,
  input  logic              captureEn,
  input  logic              baudTick,
  input  logic              ovfClear,
  output logic              muxSel,
  output logic              txLine,
  output logic              bufEmpty,
  output logic              bufFull,
  output logic              overflow
);

  dss_strobe_t strobe;
  logic        headChan;
  logic        busy;
  logic        frameFree;

  dss_ctrl #(.SETTLE_COUNT(SETTLE_COUNT), .KEEP_COUNT(KEEP_COUNT)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .convStrobe (convStrobe),
    .captureEn  (captureEn),
    .baudTick   (baudTick),
    .bufEmpty   (bufEmpty),
    .headChan   (headChan),
    .frameFree  (frameFree),
    .busy       (busy),
    .muxSel     (muxSel),
    .str        (strobe)
  );

  dss_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .str       (strobe),
    .convData  (convData),
    .ovfClear  (ovfClear),
    .headChan  (headChan),
    .bufEmpty  (bufEmpty),
    .bufFull   (bufFull),
    .overflow  (overflow),
    .txLine    (txLine),
    .busy      (busy),
    .frameFree (frameFree)
  );

endmodule

// File: tb/test_dual_sample_streamer.sv
`timescale 1ns/1ps
module test_dual_sample_streamer;

  localparam int KEEP  = 2;
  localparam int DEPTH = 8;

  typedef struct packed {
    logic [7:0] data;
    logic       keep;
    logic       chan;
    logic       selAfter;
  } vec_t;

  // Two full rotations with 3 discards and 2 keeps per input
  localparam vec_t VECS [20] = '{
    '{8'h40,1'b0,1'b0,1'b0}, '{8'h41,1'b0,1'b0,1'b0}, '{8'h42,1'b0,1'b0,1'b0},
    '{8'h93,1'b1,1'b0,1'b0}, '{8'h2C,1'b1,1'b0,1'b1},
    '{8'h45,1'b0,1'b1,1'b1}, '{8'h46,1'b0,1'b1,1'b1}, '{8'h47,1'b0,1'b1,1'b1},
    '{8'h5A,1'b1,1'b1,1'b1}, '{8'hE1,1'b1,1'b1,1'b0},
    '{8'h4A,1'b0,1'b0,1'b0}, '{8'h4B,1'b0,1'b0,1'b0}, '{8'h4C,1'b0,1'b0,1'b0},
    '{8'h01,1'b1,1'b0,1'b0}, '{8'hFE,1'b1,1'b0,1'b1},
    '{8'h4F,1'b0,1'b1,1'b1}, '{8'h50,1'b0,1'b1,1'b1}, '{8'h51,1'b0,1'b1,1'b1},
    '{8'h7E,1'b1,1'b1,1'b1}, '{8'h80,1'b1,1'b1,1'b0}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       convStrobe = 1'b0;
  logic [7:0] convData = '0;
  logic       captureEn = 1'b0;
  logic       baudTick = 1'b0;
  logic       ovfClear = 1'b0;
  logic       muxSel, txLine, bufEmpty, bufFull, overflow;

  dual_sample_streamer #(.DATA_W(8), .SETTLE_COUNT(3), .KEEP_COUNT(KEEP), .DEPTH(DEPTH))
    i_dual_sample_streamer (
      .clk(clk), .rstN(rstN), .convStrobe(convStrobe), .convData(convData),
      .captureEn(captureEn), .baudTick(baudTick), .ovfClear(ovfClear),
      .muxSel(muxSel), .txLine(txLine), .bufEmpty(bufEmpty),
      .bufFull(bufFull), .overflow(overflow));

  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Serial decoder and tick generator; ticks are one cycle every four
  bit         tickOn = 1'b0;
  int         tickDiv = 0;
  bit         inFrame = 1'b0;
  int         rxBit = 0;
  logic [7:0] rxShift = '0;
  logic [7:0] rxBytes [32];
  int         rxCount = 0;
  int         stopErr = 0;

  always @(negedge clk) begin
    if (baudTick) begin
      if (!inFrame) begin
        if (!txLine) begin inFrame = 1'b1; rxBit = 0; end
      end else if (rxBit < 8) begin
        rxShift[rxBit] = txLine;
        rxBit++;
      end else begin
        if (!txLine) stopErr++;
        if (rxCount < 32) rxBytes[rxCount] = rxShift;
        rxCount++;
        inFrame = 1'b0;
      end
    end
    if (tickOn) begin
      tickDiv = (tickDiv + 1) % 4;
      baudTick <= (tickDiv == 0);
    end else begin
      baudTick <= 1'b0;
    end
  end

  // Expected transmit stream
  logic [7:0] expBytes [32];
  bit         expIsHdr [32];
  int         expCount = 0;
  bit         expLastValid = 1'b0;
  bit         expLastChan = 1'b0;

  task automatic pushExp(input bit chan, input logic [7:0] data);
    if (!expLastValid || chan != expLastChan) begin
      expBytes[expCount] = 8'hA0 | {7'd0, chan};
      expIsHdr[expCount] = 1'b1;
      expCount++;
      expLastValid = 1'b1;
      expLastChan  = chan;
    end
    expBytes[expCount] = data;
    expIsHdr[expCount] = 1'b0;
    expCount++;
  endtask

  task automatic strobe(input logic [7:0] d);
    @(negedge clk);
    convStrobe = 1'b1;
    convData   = d;
    @(negedge clk);
    convStrobe = 1'b0;
  endtask

  task automatic waitRx(input int target);
    for (int n = 0; n < 4000 && rxCount < target; n++) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int kept;
    kept = 0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(muxSel == 1'b0,   "R9 muxSel",   muxSel, 0);
    check(txLine == 1'b1,   "R9 txLine",   txLine, 1);
    check(bufEmpty == 1'b1, "R9 bufEmpty", bufEmpty, 1);
    check(bufFull == 1'b0,  "R9 bufFull",  bufFull, 0);
    check(overflow == 1'b0, "R9 overflow", overflow, 0);
    rstN = 1'b1;
    captureEn = 1'b1;

    // Table walk: R1 select pattern, R2 discards, R10 occupancy flags
    for (int i = 0; i < 20; i++) begin
      strobe(VECS[i].data);
      if (VECS[i].keep) begin
        pushExp(VECS[i].chan, VECS[i].data);
        kept++;
      end
      check(muxSel == VECS[i].selAfter, "R1 select after strobe", muxSel, VECS[i].selAfter);
      check(bufEmpty == (kept == 0), "R2 discarded results leave buffer", bufEmpty, kept == 0);
      check(bufFull == (kept == DEPTH), "R10 full flag", bufFull, kept == DEPTH);
    end
    check(overflow == 1'b0, "R3 no drop yet", overflow, 0);

    // R3: one more kept result into a full buffer
    strobe(8'hE0); strobe(8'hE1); strobe(8'hE2); strobe(8'hE3);
    check(overflow == 1'b1, "R3 drop sets flag", overflow, 1);
    check(bufFull == 1'b1, "R10 still full", bufFull, 1);
    check(muxSel == 1'b0, "R1 select after one keep", muxSel, 0);

    // R7: strobes while capture is off are ignored
    captureEn = 1'b0;
    strobe(8'hF0); strobe(8'hF1);
    check(muxSel == 1'b0, "R7 select holds", muxSel, 0);
    check(bufFull == 1'b1, "R7 buffer unchanged", bufFull, 1);
    repeat (5) @(negedge clk);
    check(txLine == 1'b1, "R8 no frame without tick", txLine, 1);

    // Drain with capture still off (R7) and decode the line
    tickOn = 1'b1;
    waitRx(12);
    check(rxCount == 12, "R4 frame count", rxCount, 12);
    for (int k = 0; k < 12; k++) begin
      if (expIsHdr[k])
        check(rxBytes[k] == expBytes[k], "R6 header byte", rxBytes[k], expBytes[k]);
      else
        check(rxBytes[k] == expBytes[k], "R4 sample byte", rxBytes[k], expBytes[k]);
    end
    check(stopErr == 0, "R5 stop bits", stopErr, 0);
    repeat (12) @(negedge clk);
    check(bufEmpty == 1'b1, "R10 empty after drain", bufEmpty, 1);
    check(txLine == 1'b1, "R5 idle high", txLine, 1);
    check(overflow == 1'b1, "R3 flag sticky", overflow, 1);

    @(negedge clk) ovfClear = 1'b1;
    @(negedge clk) ovfClear = 1'b0;
    check(overflow == 1'b0, "R3 flag cleared", overflow, 0);

    // Second keep on input 0 completes the set; header returns to 0xA0
    captureEn = 1'b1;
    strobe(8'hC5);
    pushExp(1'b0, 8'hC5);
    check(muxSel == 1'b1, "R7 ignored strobes not counted", muxSel, 1);
    waitRx(14);
    check(rxBytes[12] == 8'hA0, "R6 header on channel change", rxBytes[12], 8'hA0);
    check(rxBytes[13] == 8'hC5, "R4 sample after gap", rxBytes[13], 8'hC5);
    check(stopErr == 0, "R5 stop bits", stopErr, 0);

    finishRun();
  end

endmodule